// File: doc/BRIEF.md
# Grouped Input Glitch Filter with Count-Edge Selector

This block conditions the asynchronous inputs of a low-power timer before the counter sees them. Every input goes through a two-flop synchronizer clocked by the internal kernel clock. A filter stage then accepts a new level only after the synchronized signal has shown that level for a programmed number of consecutive samples. Pulses shorter than that window are absorbed and cause no change.

The inputs form two groups. The count group carries clock or count inputs, and the trigger group carries trigger inputs. Each group has one 2-bit sensitivity field, and every filter in the group uses it; no input can be set on its own. Filtered count input 0 feeds an edge selector. The selector issues a one-cycle count pulse for each accepted rising edge, each accepted falling edge, or both, as selected. The filtered levels of all inputs are also brought out. The filters work only while the kernel clock runs. When both edges are counted, the kernel clock must be at least four times faster than the external signal.

Top module: `tmr_input_cond`

## Requirements
- R1: While rst_ni is low and after its release, every filtered level is 0 and cnt_pulse_o is 0 until an input has been accepted.
- R2: Sensitivity code 0 bypasses the filter. A level driven on an input appears on its filtered output at the third rising clock edge after the change, and a one-sample pulse passes.
- R3: Sensitivity codes 1, 2 and 3 require 2, 4 and 8 consecutive equal samples. A level held for exactly that many samples is accepted, and the filtered output changes at clock edge 2+N after the input change.
- R4: A run of the new level shorter than the required sample count is rejected, and the filtered output keeps its previous value.
- R5: cnt_sens_i governs every count-group input and trg_sens_i governs every trigger-group input, independently of each other.
- R6: edge_sel_i = 00 selects rising edges only: a pulse follows each accepted 0 to 1 change of count input 0 and none follows a 1 to 0 change.
- R7: edge_sel_i = 01 selects falling edges only: a pulse follows each accepted 1 to 0 change and none follows a 0 to 1 change.
- R8: edge_sel_i = 10 or 11 selects both edges: a pulse follows every accepted change of count input 0.
- R9: cnt_pulse_o is high for exactly one cycle. That cycle is the one in which filtered count level 0 has just changed.
- R10: Only count input 0 drives cnt_pulse_o. The other count inputs show up only on their filtered level outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal kernel (sampling) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_in_i | input | N_CNT | Asynchronous count/clock inputs |
| trg_in_i | input | N_TRG | Asynchronous trigger inputs |
| cnt_sens_i | input | 2 | Count-group sensitivity: 0 bypass, 1/2/3 = 2/4/8 samples |
| trg_sens_i | input | 2 | Trigger-group sensitivity, same encoding |
| edge_sel_i | input | 2 | Active edge: 00 rising, 01 falling, 1x both |
| cnt_lvl_o | output | N_CNT | Filtered count-group levels |
| trg_lvl_o | output | N_TRG | Filtered trigger-group levels |
| cnt_pulse_o | output | 1 | One-cycle count pulse from count input 0 |

## Verification
The assertions assume the sensitivity fields and the edge selection change only while the inputs are steady. The filter check reads the previous cycle's setting. The rule that a pulse lasts one cycle in both-edge mode also depends on the input staying steady for several kernel clocks, which is the four-times-faster rule. The stimulus keeps to these limits. Settings change only after every expected pulse has arrived. Each accepted level is held for at least twelve clocks, so only deliberately short runs are shorter than the filter window.

// File: rtl/tmr_incond_pkg.sv
package tmr_incond_pkg;
  localparam int unsigned SENS_W = 2;
  localparam int unsigned MAX_LEN = 8;
  localparam int unsigned LEN_W = $clog2(MAX_LEN) + 1;
  localparam int unsigned RUN_W = $clog2(MAX_LEN);

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  // required consecutive-sample count; 1 means bypass
  function automatic logic [LEN_W-1:0] sens_to_len(input logic [SENS_W-1:0] s);
    case (s)
      2'd1:    sens_to_len = LEN_W'(2);
      2'd2:    sens_to_len = LEN_W'(4);
      2'd3:    sens_to_len = LEN_W'(8);
      default: sens_to_len = LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/filt_group.sv
module filt_group
  import tmr_incond_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      smp_i,
  input  logic [SENS_W-1:0] sens_i,
  output logic [W-1:0]      lvl_o
);
  logic [LEN_W-1:0] len;
  logic             bypass;

  assign len    = sens_to_len(sens_i);
  assign bypass = (sens_i == '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [RUN_W-1:0] run_q;
    logic             lvl_q;
    logic [LEN_W-1:0] run_nxt;

    assign run_nxt = LEN_W'(run_q) + LEN_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q <= '0;
        lvl_q <= 1'b0;
      end else if (bypass) begin
        run_q <= '0;
        lvl_q <= smp_i[i];
      end else if (smp_i[i] == lvl_q) begin
        run_q <= '0;
      end else if (run_nxt >= len) begin
        // >= keeps the run bounded if the setting drops mid-run
        run_q <= '0;
        lvl_q <= smp_i[i];
      end else begin
        run_q <= run_nxt[RUN_W-1:0];
      end
    end

    assign lvl_o[i] = lvl_q;
  end
endmodule

// File: rtl/edge_pick.sv
module edge_pick
  import tmr_incond_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] sel_i,
  output logic       pulse_o
);
  logic      lvl_q;
  logic      rise, fall;
  edge_sel_e sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign sel  = edge_sel_e'(sel_i);
  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;

  always_comb begin
    case (sel)
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      default:   pulse_o = rise | fall;
    endcase
  end
endmodule

// File: rtl/tmr_input_cond.sv
module tmr_input_cond
  import tmr_incond_pkg::*;
#(
  parameter int unsigned N_CNT = 2,
  parameter int unsigned N_TRG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CNT-1:0]  cnt_in_i,
  input  logic [N_TRG-1:0]  trg_in_i,
  input  logic [SENS_W-1:0] cnt_sens_i,
  input  logic [SENS_W-1:0] trg_sens_i,
  input  logic [1:0]        edge_sel_i,
  output logic [N_CNT-1:0]  cnt_lvl_o,
  output logic [N_TRG-1:0]  trg_lvl_o,
  output logic              cnt_pulse_o
);
  logic [N_CNT-1:0] cnt_sync;
  logic [N_TRG-1:0] trg_sync;

  in_sync #(.W(N_CNT)) u_cnt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_in_i), .q_o(cnt_sync)
  );

  in_sync #(.W(N_TRG)) u_trg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trg_in_i), .q_o(trg_sync)
  );

  filt_group #(.W(N_CNT)) u_cnt_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(cnt_sync),
    .sens_i(cnt_sens_i), .lvl_o(cnt_lvl_o)
  );

  filt_group #(.W(N_TRG)) u_trg_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(trg_sync),
    .sens_i(trg_sens_i), .lvl_o(trg_lvl_o)
  );

  edge_pick u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(cnt_lvl_o[0]),
    .sel_i(edge_sel_i), .pulse_o(cnt_pulse_o)
  );
endmodule

// File: rtl/tmr_input_cond_chk.sv
module tmr_input_cond_chk #(
  parameter int unsigned N_CNT = 2,
  parameter int unsigned N_TRG = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cnt_sens_i,
  input logic [1:0]       trg_sens_i,
  input logic [1:0]       edge_sel_i,
  input logic [N_CNT-1:0] cnt_lvl_o,
  input logic [N_TRG-1:0] trg_lvl_o,
  input logic             cnt_pulse_o,
  input logic [N_CNT-1:0] cnt_sync_i,
  input logic [N_TRG-1:0] trg_sync_i
);
  assert_pulse_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_pulse_o |-> (cnt_lvl_o[0] != $past(cnt_lvl_o[0])));

  assert_rise_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b00 && cnt_pulse_o) |-> cnt_lvl_o[0]);

  assert_fall_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b01 && cnt_pulse_o) |-> !cnt_lvl_o[0]);

  assert_both_edges_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i[1] && cnt_lvl_o[0] != $past(cnt_lvl_o[0])) |-> cnt_pulse_o);

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    assert_cnt_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_sens_i) == 2'd0) |-> (cnt_lvl_o[i] == $past(cnt_sync_i[i])));
    assert_cnt_min_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_sens_i) != 2'd0 && cnt_lvl_o[i] != $past(cnt_lvl_o[i]))
      |-> ($past(cnt_sync_i[i]) == cnt_lvl_o[i] && $past(cnt_sync_i[i], 2) == cnt_lvl_o[i]));
  end

  for (genvar i = 0; i < N_TRG; i++) begin : g_trg
    assert_trg_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(trg_sens_i) == 2'd0) |-> (trg_lvl_o[i] == $past(trg_sync_i[i])));
    assert_trg_min_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(trg_sens_i) != 2'd0 && trg_lvl_o[i] != $past(trg_lvl_o[i]))
      |-> ($past(trg_sync_i[i]) == trg_lvl_o[i] && $past(trg_sync_i[i], 2) == trg_lvl_o[i]));
  end
endmodule

bind tmr_input_cond tmr_input_cond_chk #(.N_CNT(N_CNT), .N_TRG(N_TRG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_sens_i(cnt_sens_i), .trg_sens_i(trg_sens_i),
  .edge_sel_i(edge_sel_i), .cnt_lvl_o(cnt_lvl_o), .trg_lvl_o(trg_lvl_o),
  .cnt_pulse_o(cnt_pulse_o), .cnt_sync_i(cnt_sync), .trg_sync_i(trg_sync)
);

// File: tb/sim_tmr_input_cond.sv
module sim_tmr_input_cond;
  localparam int NC = 2;
  localparam int NT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] cnt_in;
  logic [NT-1:0] trg_in;
  logic [1:0]    cnt_sens, trg_sens, edge_sel;
  logic [NC-1:0] cnt_lvl;
  logic [NT-1:0] trg_lvl;
  logic          cnt_pulse;

  tmr_input_cond #(.N_CNT(NC), .N_TRG(NT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .trg_in_i(trg_in),
    .cnt_sens_i(cnt_sens), .trg_sens_i(trg_sens), .edge_sel_i(edge_sel),
    .cnt_lvl_o(cnt_lvl), .trg_lvl_o(trg_lvl), .cnt_pulse_o(cnt_pulse)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  logic  model_lvl = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'd1:    return 2;
      2'd2:    return 4;
      2'd3:    return 8;
      default: return 1;
    endcase
  endfunction

  function automatic bit edge_ok(input logic [1:0] sel, input logic v);
    if (sel == 2'b00) return v;
    if (sel == 2'b01) return !v;
    return 1'b1;
  endfunction

  // monitor: every pulse must match the head of the expectation queue
  always @(negedge clk) begin
    int e;
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        e = exp_q.pop_front();
        chk(1'b0, {cur_req, " pulse missing"}, cyc, e);
      end
      if (cnt_pulse) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_req, " R9 unexpected pulse"}, cyc, -1);
        else begin
          e = exp_q.pop_front();
          chk(e == cyc, {cur_req, " R9 pulse cycle"}, cyc, e);
        end
      end
    end
  end

  // driver: sets count input 0, predicts acceptance and pulse cycle
  task automatic cnt_level(input logic v, input int hold, input string req);
    int m = len_of(cnt_sens);
    int k;
    @(posedge clk); #2;
    k = cyc;
    cur_req = req;
    cnt_in[0] = v;
    if (hold >= m && v != model_lvl) begin
      model_lvl = v;
      if (edge_ok(edge_sel, v)) exp_q.push_back(k + 2 + m);
    end
    if (hold > 1) repeat (hold - 1) @(posedge clk);
    if (hold >= m + 3) begin
      @(negedge clk);
      chk(cnt_lvl[0] == model_lvl, {req, " count level"}, int'(cnt_lvl[0]), int'(model_lvl));
    end
  endtask

  task automatic trg_burst(input int idx, input int h, input logic exp, input string req);
    int m = len_of(trg_sens);
    int k;
    @(posedge clk); #2;
    k = cyc;
    trg_in[idx] = 1'b1;
    if (h > 1) repeat (h - 1) @(posedge clk);
    @(posedge clk); #2;
    trg_in[idx] = 1'b0;
    do @(negedge clk); while (cyc < k + 2 + m);
    chk(trg_lvl[idx] == exp, {req, " trigger level"}, int'(trg_lvl[idx]), int'(exp));
    chk(trg_lvl[1-idx] == 1'b0, {req, " other trigger untouched"}, int'(trg_lvl[1-idx]), 0);
    repeat (m + 6) @(posedge clk);
    @(negedge clk);
    chk(trg_lvl == '0, {req, " trigger returns low"}, int'(trg_lvl), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    cnt_in   = '0;
    trg_in   = '0;
    cnt_sens = 2'd0;
    trg_sens = 2'd0;
    edge_sel = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cnt_lvl == '0 && trg_lvl == '0 && !cnt_pulse, "R1 reset state",
        int'({cnt_lvl, trg_lvl, cnt_pulse}), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cnt_lvl == '0 && trg_lvl == '0, "R1 after release", int'({cnt_lvl, trg_lvl}), 0);

    // R2 bypass: even a one-sample pulse passes
    cnt_level(1'b1, 12, "R2");
    cnt_level(1'b0, 12, "R2");
    cnt_level(1'b1, 1, "R2");
    cnt_level(1'b0, 12, "R2");

    // R3 / R4 for each filter length
    cnt_sens = 2'd1;
    cnt_level(1'b1, 1, "R4");
    cnt_level(1'b0, 12, "R4");
    cnt_level(1'b1, 2, "R3");
    cnt_level(1'b0, 12, "R3");
    cnt_sens = 2'd2;
    cnt_level(1'b1, 3, "R4");
    cnt_level(1'b0, 12, "R4");
    cnt_level(1'b1, 4, "R3");
    cnt_level(1'b0, 12, "R3");
    cnt_sens = 2'd3;
    cnt_level(1'b1, 7, "R4");
    cnt_level(1'b0, 12, "R4");
    cnt_level(1'b1, 12, "R3");
    cnt_level(1'b0, 12, "R3");

    // edge selection
    cnt_sens = 2'd1;
    edge_sel = 2'b00;
    cnt_level(1'b1, 12, "R6");
    cnt_level(1'b0, 12, "R6");
    edge_sel = 2'b01;
    cnt_level(1'b1, 12, "R7");
    cnt_level(1'b0, 12, "R7");
    edge_sel = 2'b11;
    cnt_level(1'b1, 12, "R8");
    cnt_level(1'b0, 12, "R8");
    edge_sel = 2'b10;
    cnt_level(1'b1, 12, "R8");
    cnt_level(1'b0, 12, "R8");

    // R10: count input 1 filters but never pulses
    cur_req = "R10";
    @(posedge clk); #2;
    cnt_in[1] = 1'b1;
    repeat (8) @(negedge clk);
    chk(cnt_lvl[1] == 1'b1, "R10 second count level", int'(cnt_lvl[1]), 1);
    @(posedge clk); #2;
    cnt_in[1] = 1'b0;
    repeat (8) @(negedge clk);
    chk(cnt_lvl[1] == 1'b0, "R10 second count level low", int'(cnt_lvl[1]), 0);

    // R5: trigger group has its own setting
    cur_req  = "R5";
    trg_sens = 2'd3;
    cnt_sens = 2'd1;
    trg_burst(0, 7, 1'b0, "R5");
    trg_burst(1, 8, 1'b1, "R5");
    trg_sens = 2'd1;
    cnt_sens = 2'd3;
    trg_burst(0, 2, 1'b1, "R5");
    trg_burst(1, 1, 1'b0, "R5");
    trg_sens = 2'd0;
    trg_burst(1, 1, 1'b1, "R5");

    repeat (20) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    chk(exp_q.size() == 0, "R9 all pulses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule